// File: doc/BRIEF.md
# Skip-Next Conditional Unit

This unit makes the skip decision for the conditional instructions of a small core built around a single working register (W). Each one either tests one bit of a file byte, or steps a file byte up or down by one and tests the new value for zero. A true condition raises a one-cycle skip request. The core uses that request to turn the instruction it fetches next into a no-op. The core has no branch-on-flag instructions, so every conditional is built from this skip and an unconditional jump.

The core presents an instruction by raising `valid_i` along with the operation, the operand byte it read from the file, a bit index and a destination select. One clock later the unit shows its outputs:
- the result byte,
- a write strobe for W or for the file register,
- the skip request.

An instruction presented while `skip_o` is high is the discarded one. The unit swallows it, so it writes nothing and raises no skip. None of the operations touch the STATUS flags, so the unit has no flag output. The program counter logic only has to see `skip_o`.

Top module: `skip_unit`

## Requirements
- R1: While `rst_ni` is low, and in the cycle after it is released, `result_o` reads 0x00 and `w_we_o`, `f_we_o` and `skip_o` are all low.
- R2: Operation code 0 (test bit, skip if clear) raises `skip_o` when bit `bit_idx_i` of `operand_i` is 0. The 3-bit index selects bit 0 through 7.
- R3: Operation code 1 (test bit, skip if set) raises `skip_o` when bit `bit_idx_i` of `operand_i` is 1.
- R4: After either bit-test operation, `w_we_o` and `f_we_o` stay low and `result_o` reads 0x00.
- R5: Operation code 2 (decrement) gives `result_o` = operand − 1 modulo 256. It raises `skip_o` only when that value is 0x00, so 0x00 wraps to 0xFF and does not skip.
- R6: Operation code 3 (increment) gives `result_o` = operand + 1 modulo 256. It raises `skip_o` only when that value wraps to 0x00, which happens for operand 0xFF.
- R7: For a counting operation, `dest_f_i` = 1 raises only `f_we_o` and `dest_f_i` = 0 raises only `w_we_o`. With the W destination the file register gets no write strobe. The two strobes are never high together.
- R8: All outputs appear on the clock edge that samples the instruction and last exactly one cycle. `skip_o` is never high for two cycles in a row.
- R9: An instruction presented in a cycle where `skip_o` is high is discarded. On the next cycle there is no write strobe, no skip and `result_o` reads 0x00.
- R10: A cycle with `valid_i` low leaves all strobes and `skip_o` low on the next cycle, whatever the other inputs are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | A conditional instruction is presented this cycle |
| op_i | input | 2 | 0 test/skip-if-clear, 1 test/skip-if-set, 2 decrement/skip-if-zero, 3 increment/skip-if-zero |
| operand_i | input | 8 | File byte read by the instruction |
| bit_idx_i | input | 3 | Bit position tested by operation codes 0 and 1 |
| dest_f_i | input | 1 | Counting result goes to the file register (1) or W (0) |
| result_o | output | 8 | Counting result, 0x00 otherwise |
| w_we_o | output | 1 | Write strobe for W |
| f_we_o | output | 1 | Write strobe for the file register |
| skip_o | output | 1 | Discard the next fetched instruction |

## Verification
All results, strobes and the skip come out of one register stage. They are therefore due on the first rising edge after the instruction is driven. The bench drives on falling edges and compares every output on the next falling edge, half a cycle after the edge that loaded them. It puts an idle cycle between the table vectors, so a skip raised by one vector cannot swallow the next. The squash case then presents a second instruction on purpose during the skip cycle and checks that the cycle after it is empty.

// File: rtl/skip_unit_pkg.sv
package skip_unit_pkg;
  typedef enum logic [1:0] {
    OP_TST_CLR = 2'd0,
    OP_TST_SET = 2'd1,
    OP_DEC_SKZ = 2'd2,
    OP_INC_SKZ = 2'd3
  } skip_op_e;
endpackage

// File: rtl/skip_bit_sel.sv
module skip_bit_sel #(
  parameter int DATA_W = 8,
  localparam int IDX_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] operand_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic              bit_o
);
  logic [DATA_W-1:0] hit;

  for (genvar g = 0; g < DATA_W; g++) begin : g_hit
    assign hit[g] = (idx_i == IDX_W'(g)) & operand_i[g];
  end

  assign bit_o = |hit;

  always_comb begin
    assert ($onehot0(hit)) else $error("p_one_bit_r2");
  end
endmodule

// File: rtl/skip_step.sv
module skip_step #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] operand_i,
  input  logic              up_i,
  output logic [DATA_W-1:0] sum_o,
  output logic              zero_o
);
  always_comb begin
    if (up_i) sum_o = operand_i + DATA_W'(1);
    else      sum_o = operand_i - DATA_W'(1);
  end

  assign zero_o = (sum_o == '0);
endmodule

// File: rtl/skip_issue_reg.sv
module skip_issue_reg
  import skip_unit_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              issue_i,
  input  skip_op_e          op_i,
  input  logic              bit_i,
  input  logic [DATA_W-1:0] sum_i,
  input  logic              zero_i,
  input  logic              dest_f_i,
  output logic [DATA_W-1:0] result_o,
  output logic              w_we_o,
  output logic              f_we_o,
  output logic              skip_o
);
  logic              is_cnt;
  logic              cond;
  logic [DATA_W-1:0] res_d;

  assign is_cnt = (op_i == OP_DEC_SKZ) || (op_i == OP_INC_SKZ);

  always_comb begin
    unique case (op_i)
      OP_TST_CLR: cond = ~bit_i;
      OP_TST_SET: cond = bit_i;
      default:    cond = zero_i;
    endcase
  end

  assign res_d = (issue_i && is_cnt) ? sum_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o <= '0;
      w_we_o   <= 1'b0;
      f_we_o   <= 1'b0;
      skip_o   <= 1'b0;
    end else begin
      result_o <= res_d;
      w_we_o   <= issue_i & is_cnt & ~dest_f_i;
      f_we_o   <= issue_i & is_cnt & dest_f_i;
      skip_o   <= issue_i & cond;
    end
  end

  p_bit_no_write_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_i && !is_cnt |=> !w_we_o && !f_we_o && result_o == '0);

  p_dest_w_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_i && is_cnt && !dest_f_i |=> w_we_o && !f_we_o);
endmodule

// File: rtl/skip_unit.sv
module skip_unit
  import skip_unit_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int IDX_W = $clog2(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [1:0]        op_i,
  input  logic [DATA_W-1:0] operand_i,
  input  logic [IDX_W-1:0]  bit_idx_i,
  input  logic              dest_f_i,
  output logic [DATA_W-1:0] result_o,
  output logic              w_we_o,
  output logic              f_we_o,
  output logic              skip_o
);
  skip_op_e          op;
  logic              issue;
  logic              sel_bit;
  logic [DATA_W-1:0] sum;
  logic              zero;

  assign op    = skip_op_e'(op_i);
  // the instruction fetched behind a taken skip is the one discarded
  assign issue = valid_i & ~skip_o;

  skip_bit_sel #(.DATA_W(DATA_W)) u_bit_sel (
    .operand_i (operand_i),
    .idx_i     (bit_idx_i),
    .bit_o     (sel_bit)
  );

  skip_step #(.DATA_W(DATA_W)) u_step (
    .operand_i (operand_i),
    .up_i      (op == OP_INC_SKZ),
    .sum_o     (sum),
    .zero_o    (zero)
  );

  skip_issue_reg #(.DATA_W(DATA_W)) u_issue_reg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .issue_i  (issue),
    .op_i     (op),
    .bit_i    (sel_bit),
    .sum_i    (sum),
    .zero_i   (zero),
    .dest_f_i (dest_f_i),
    .result_o (result_o),
    .w_we_o   (w_we_o),
    .f_we_o   (f_we_o),
    .skip_o   (skip_o)
  );

  p_tst_clr_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !skip_o && op_i == 2'd0 && !operand_i[bit_idx_i] |=> skip_o);

  p_tst_set_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !skip_o && op_i == 2'd1 && operand_i[bit_idx_i] |=> skip_o);

  p_dec_value_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !skip_o && op_i == 2'd2 |=> result_o == DATA_W'($past(operand_i) - 1'b1));

  p_inc_wrap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !skip_o && op_i == 2'd3 && operand_i == '1 |=> skip_o && result_o == '0);

  p_one_we_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({w_we_o, f_we_o}));

  p_skip_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    skip_o |=> !skip_o);

  p_squash_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    skip_o |=> !w_we_o && !f_we_o && result_o == '0);

  p_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !w_we_o && !f_we_o && !skip_o);
endmodule

// File: tb/tb_skip_unit.sv
`timescale 1ns/1ps
module tb_skip_unit;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       valid_i = 1'b0;
  logic [1:0] op_i = '0;
  logic [7:0] operand_i = '0;
  logic [2:0] bit_idx_i = '0;
  logic       dest_f_i = 1'b0;
  logic [7:0] result_o;
  logic       w_we_o, f_we_o, skip_o;

  int n_run = 0;
  int n_fail = 0;

  always #4 clk_i = ~clk_i;

  skip_unit dut (
    .clk_i, .rst_ni, .valid_i, .op_i, .operand_i, .bit_idx_i, .dest_f_i,
    .result_o, .w_we_o, .f_we_o, .skip_o
  );

  // {op, operand, idx, dest_f, exp_result, exp_w, exp_f, exp_skip}
  localparam int NV = 12;
  localparam logic [24:0] VEC [NV] = '{
    {2'd0, 8'hFE, 3'd0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1},  // R2 bit0 clear
    {2'd0, 8'h01, 3'd0, 1'b1, 8'h00, 1'b0, 1'b0, 1'b0},  // R2 bit0 set
    {2'd0, 8'h20, 3'd5, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0},  // R2 bit5 set
    {2'd1, 8'h80, 3'd7, 1'b1, 8'h00, 1'b0, 1'b0, 1'b1},  // R3 bit7 set
    {2'd1, 8'h7F, 3'd7, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0},  // R3 bit7 clear
    {2'd1, 8'h08, 3'd3, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1},  // R3 bit3 set
    {2'd2, 8'h01, 3'd0, 1'b1, 8'h00, 1'b0, 1'b1, 1'b1},  // R5 to zero
    {2'd2, 8'h00, 3'd0, 1'b0, 8'hFF, 1'b1, 1'b0, 1'b0},  // R5 wrap down
    {2'd2, 8'h80, 3'd2, 1'b1, 8'h7F, 1'b0, 1'b1, 1'b0},  // R5
    {2'd3, 8'hFF, 3'd0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b1},  // R6 wrap
    {2'd3, 8'hFE, 3'd0, 1'b1, 8'hFF, 1'b0, 1'b1, 1'b0},  // R6
    {2'd3, 8'h00, 3'd6, 1'b0, 8'h01, 1'b1, 1'b0, 1'b0}   // R6
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic check_all(input string tag, input logic [7:0] r, input logic w,
                           input logic f, input logic s);
    check({tag, " result"}, result_o, r);
    check({tag, " w_we"}, {7'd0, w_we_o}, {7'd0, w});
    check({tag, " f_we"}, {7'd0, f_we_o}, {7'd0, f});
    check({tag, " skip"}, {7'd0, skip_o}, {7'd0, s});
  endtask

  task automatic drive(input logic v, input logic [1:0] op, input logic [7:0] opd,
                       input logic [2:0] idx, input logic d);
    valid_i = v; op_i = op; operand_i = opd; bit_idx_i = idx; dest_f_i = d;
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    drive(1'b1, 2'd3, 8'hFF, 3'd0, 1'b1);
    repeat (3) @(negedge clk_i);
    check_all("R1 in reset", 8'h00, 1'b0, 1'b0, 1'b0);
    drive(1'b0, 2'd0, 8'h00, 3'd0, 1'b0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check_all("R1 after reset", 8'h00, 1'b0, 1'b0, 1'b0);

    for (int i = 0; i < NV; i++) begin
      logic [24:0] v;
      v = VEC[i];
      drive(1'b1, v[24:23], v[22:15], v[14:12], v[11]);
      @(negedge clk_i);
      drive(1'b0, 2'd0, 8'h00, 3'd0, 1'b0);
      check_all($sformatf("R2-6 vec%0d R4 R7", i), v[10:3], v[2], v[1], v[0]);
      @(negedge clk_i);
      check_all($sformatf("R8 vec%0d gap", i), 8'h00, 1'b0, 1'b0, 1'b0);
    end

    // R9: instruction behind a taken skip is swallowed
    drive(1'b1, 2'd2, 8'h01, 3'd0, 1'b1);
    @(negedge clk_i);
    check_all("R9 skip taken", 8'h00, 1'b0, 1'b1, 1'b1);
    drive(1'b1, 2'd3, 8'hFF, 3'd0, 1'b0);
    @(negedge clk_i);
    check_all("R9 squashed", 8'h00, 1'b0, 1'b0, 1'b0);
    drive(1'b1, 2'd3, 8'hFF, 3'd0, 1'b0);
    @(negedge clk_i);
    check_all("R9 next runs", 8'h00, 1'b1, 1'b0, 1'b1);

    // R10: valid low ignored
    drive(1'b0, 2'd3, 8'hFF, 3'd0, 1'b1);
    @(negedge clk_i);
    check_all("R10 idle inc", 8'h00, 1'b0, 1'b0, 1'b0);
    drive(1'b0, 2'd0, 8'h00, 3'd4, 1'b0);
    @(negedge clk_i);
    check_all("R10 idle tst", 8'h00, 1'b0, 1'b0, 1'b0);

    // R8: back-to-back non-skipping instructions each last one cycle
    drive(1'b1, 2'd2, 8'h05, 3'd0, 1'b0);
    @(negedge clk_i);
    check_all("R8 b2b first", 8'h04, 1'b1, 1'b0, 1'b0);
    drive(1'b1, 2'd1, 8'h00, 3'd1, 1'b0);
    @(negedge clk_i);
    check_all("R8 b2b second R3", 8'h00, 1'b0, 1'b0, 1'b0);
    drive(1'b0, 2'd0, 8'h00, 3'd0, 1'b0);
    @(negedge clk_i);
    check_all("R8 b2b drain", 8'h00, 1'b0, 1'b0, 1'b0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule